// File: doc/BRIEF.md
# Transmit Deadlock Guard

This block sits between transmit software control and a half-duplex Ethernet MAC transmitter. That transmitter can lock up: its request flag stays set, and it never signals completion or error. For every frame, the guard first holds the transmit logic in reset for a short pulse. It then waits a settling interval, measured in clock cycles and derived from a time given in nanoseconds, so that at least 1.6 µs passes at the real clock. Only after that does it raise the transmit request.

While the request is raised, a timeout timer runs. The timer starts from zero each time the request goes up. If the MAC reports completion, the guard drops the request, emits a one-cycle done pulse and returns to idle. If the timer expires first, the guard treats the transmitter as hung. It drops the request, resets the transmit logic again, waits out the settle time and retries. After a configured number of retries it stops and emits a give-up pulse.

A retry count for the current frame is visible on the ports, and it saturates at its own width. Error flags that the MAC raises while it is held in reset or settling are spurious and are filtered out. The default timeout is 3 ms, which leaves room for a maximum-length frame at 10 Mb/s plus collision backoff.

Top module: `tx_deadlock_guard`

## Requirements
- R1: While and after reset, txrst_o, req_o, done_o, giveup_o and tx_err_o are 0 and retry_cnt_o is 0.
- R2: A send_i seen in idle makes txrst_o high from the next cycle for exactly RST_CYC consecutive cycles.
- R3: After txrst_o falls, req_o stays low for exactly SETTLE_CYC cycles (the ceiling of SETTLE_NS times CLK_HZ over 1e9, at least 1), then rises.
- R4: txrst_o and req_o are never high in the same cycle.
- R5: If req_clr_i or mac_done_i is high while req_o is high, req_o falls at that edge and done_o is high for exactly that one following cycle, reporting the frame's retry_cnt_o.
- R6: If req_o has been high for TO_CYC cycles without completion, req_o falls and txrst_o rises in the same cycle, a new reset/settle/request sequence follows, and the retry count rises by one.
- R7: Each request window, first or retry, restarts the timer; a completion seen in the last (TO_CYC-th) cycle of a window counts as completion, not timeout.
- R8: Once MAX_RETRY retries have been made and the next window also times out, req_o falls, giveup_o pulses for one cycle, txrst_o stays low and the block returns to idle.
- R9: retry_cnt_o counts retries of the current frame, saturates at 2^CNT_W-1 and returns to 0 when the next send is accepted.
- R10: mac_err_i is ignored outside the request phase; while req_o is high it appears on tx_err_o one cycle later.
- R11: send_i while a frame is in progress has no effect on the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| send_i | input | 1 | Start a frame (accepted in idle) |
| mac_done_i | input | 1 | MAC transmit-complete indication |
| req_clr_i | input | 1 | MAC has cleared the request flag |
| mac_err_i | input | 1 | MAC transmit-error indication |
| txrst_o | output | 1 | Transmit-logic reset pulse |
| req_o | output | 1 | Transmit request flag |
| done_o | output | 1 | One-cycle frame-completed pulse |
| giveup_o | output | 1 | One-cycle retries-exhausted pulse |
| tx_err_o | output | 1 | Filtered transmit error, delayed one cycle |
| retry_cnt_o | output | CNT_W | Saturating retry count of the current frame |

## Verification
A wrong phase state or a miscounting phase timer shows up as a reset pulse, settle gap or request window of the wrong length. The scoreboard sees that at the very edge where the phase ends. A retry counter that fails to restart or to saturate is exposed at the next done or give-up pulse, which carries the count. A broken error filter appears on tx_err_o one cycle after the stray error. A request that completes in the last cycle of its window separates a correct completion from a wrongly taken timeout within that cycle.

// File: rtl/tdw_pkg.sv
package tdw_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RST    = 2'd1,
        ST_SETTLE = 2'd2,
        ST_REQ    = 2'd3
    } tdw_state_e;

    typedef struct packed {
        logic done;
        logic giveup;
        logic err;
    } tdw_pulse_s;

    // Round a time in ns up to whole clock cycles, never below one.
    function automatic int unsigned ns_to_cyc(input longint unsigned ns,
                                              input longint unsigned hz);
        longint unsigned c;
        c = (ns * hz + 64'd999_999_999) / 64'd1_000_000_000;
        if (c == 0) c = 1;
        return c[31:0];
    endfunction

    function automatic int unsigned max3(input int unsigned a,
                                         input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/tdw_phase_timer.sv
module tdw_phase_timer #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         restart,
    output logic [W-1:0] cnt_o
);
    always_ff @(posedge clk) begin
        if (rst || restart)
            cnt_o <= '0;
        else if (cnt_o != '1)
            cnt_o <= cnt_o + 1'b1;
    end
endmodule

// File: rtl/tdw_retry_ctr.sv
module tdw_retry_ctr #(
    parameter int unsigned MAX_RETRY = 3,
    parameter int unsigned CNT_W     = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             bump,
    output logic             exhausted_o,
    output logic [CNT_W-1:0] cnt_o
);
    localparam int unsigned IW = (MAX_RETRY < 1) ? 1 : $clog2(MAX_RETRY + 1);

    logic [IW-1:0] tries_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            tries_q <= '0;
            cnt_o   <= '0;
        end else if (bump) begin
            tries_q <= tries_q + 1'b1;
            if (cnt_o != '1)
                cnt_o <= cnt_o + 1'b1;
        end
    end

    assign exhausted_o = (tries_q == IW'(MAX_RETRY));
endmodule

// File: rtl/tx_deadlock_guard.sv
module tx_deadlock_guard
    import tdw_pkg::*;
#(
    parameter longint unsigned CLK_HZ     = 50_000_000,
    parameter longint unsigned SETTLE_NS  = 1_600,
    parameter longint unsigned TIMEOUT_NS = 3_000_000,
    parameter int unsigned     RST_CYC    = 2,
    parameter int unsigned     MAX_RETRY  = 3,
    parameter int unsigned     CNT_W      = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             send_i,
    input  logic             mac_done_i,
    input  logic             req_clr_i,
    input  logic             mac_err_i,
    output logic             txrst_o,
    output logic             req_o,
    output logic             done_o,
    output logic             giveup_o,
    output logic             tx_err_o,
    output logic [CNT_W-1:0] retry_cnt_o
);
    localparam int unsigned SETTLE_CYC = ns_to_cyc(SETTLE_NS, CLK_HZ);
    localparam int unsigned TO_CYC     = ns_to_cyc(TIMEOUT_NS, CLK_HZ);
    localparam int unsigned RST_LEN    = (RST_CYC < 1) ? 1 : RST_CYC;
    localparam int unsigned LONGEST    = max3(RST_LEN, SETTLE_CYC, TO_CYC);
    localparam int unsigned TW         = $clog2(LONGEST + 1);

    tdw_state_e state_q, state_d;
    tdw_pulse_s pulse_q, pulse_d;
    logic [TW-1:0] tcnt;
    logic restart, clr_retry, bump, exhausted;
    logic rst_end, settle_end, req_end, complete;

    tdw_phase_timer #(.W(TW)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .restart (restart),
        .cnt_o   (tcnt)
    );

    tdw_retry_ctr #(.MAX_RETRY(MAX_RETRY), .CNT_W(CNT_W)) u_retry (
        .clk         (clk),
        .rst         (rst),
        .clear       (clr_retry),
        .bump        (bump),
        .exhausted_o (exhausted),
        .cnt_o       (retry_cnt_o)
    );

    assign rst_end    = (tcnt == TW'(RST_LEN - 1));
    assign settle_end = (tcnt == TW'(SETTLE_CYC - 1));
    assign req_end    = (tcnt == TW'(TO_CYC - 1));
    assign complete   = req_clr_i || mac_done_i;

    always_comb begin
        state_d   = state_q;
        restart   = 1'b0;
        clr_retry = 1'b0;
        bump      = 1'b0;
        pulse_d   = '0;
        pulse_d.err = (state_q == ST_REQ) && mac_err_i;
        unique case (state_q)
            ST_IDLE: begin
                if (send_i) begin
                    state_d   = ST_RST;
                    restart   = 1'b1;
                    clr_retry = 1'b1;
                end
            end
            ST_RST: begin
                if (rst_end) begin
                    state_d = ST_SETTLE;
                    restart = 1'b1;
                end
            end
            ST_SETTLE: begin
                if (settle_end) begin
                    state_d = ST_REQ;
                    restart = 1'b1;
                end
            end
            ST_REQ: begin
                if (complete) begin
                    state_d      = ST_IDLE;
                    pulse_d.done = 1'b1;
                end else if (req_end) begin
                    if (exhausted) begin
                        state_d        = ST_IDLE;
                        pulse_d.giveup = 1'b1;
                    end else begin
                        state_d = ST_RST;
                        restart = 1'b1;
                        bump    = 1'b1;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            pulse_q <= '0;
        end else begin
            state_q <= state_d;
            pulse_q <= pulse_d;
        end
    end

    assign txrst_o  = (state_q == ST_RST);
    assign req_o    = (state_q == ST_REQ);
    assign done_o   = pulse_q.done;
    assign giveup_o = pulse_q.giveup;
    assign tx_err_o = pulse_q.err;

endmodule

// File: rtl/tx_deadlock_guard_chk.sv
module tx_deadlock_guard_chk #(
    parameter int unsigned SETTLE_CYC = 80,
    parameter int unsigned TO_CYC     = 150_000,
    parameter int unsigned CNT_W      = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             txrst_o,
    input logic             req_o,
    input logic             done_o,
    input logic             giveup_o,
    input logic             tx_err_o,
    input logic [CNT_W-1:0] retry_cnt_o
);
    int unsigned gap_q;
    int unsigned run_q;

    always_ff @(posedge clk) begin
        if (rst || txrst_o)
            gap_q <= 0;
        else if (!req_o && gap_q != 32'hFFFF_FFFF)
            gap_q <= gap_q + 1;
        if (rst || !req_o)
            run_q <= 0;
        else
            run_q <= run_q + 1;
    end

    p_no_overlap_r4: assert property (@(posedge clk) disable iff (rst)
        !(txrst_o && req_o));

    p_settle_gap_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(req_o) |-> gap_q == SETTLE_CYC);

    p_window_bound_r6: assert property (@(posedge clk) disable iff (rst)
        req_o |-> run_q < TO_CYC);

    p_done_ends_req_r5: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (!req_o && $past(req_o)));

    p_giveup_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        giveup_o |-> (!txrst_o && !req_o && $past(req_o)));

    p_count_moves_r9: assert property (@(posedge clk) disable iff (rst)
        !$stable(retry_cnt_o) |-> (retry_cnt_o == '0) || (txrst_o && $past(req_o)));

    p_err_filter_r10: assert property (@(posedge clk) disable iff (rst)
        tx_err_o |-> $past(req_o));

endmodule

bind tx_deadlock_guard tx_deadlock_guard_chk #(
    .SETTLE_CYC (SETTLE_CYC),
    .TO_CYC     (TO_CYC),
    .CNT_W      (CNT_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .txrst_o     (txrst_o),
    .req_o       (req_o),
    .done_o      (done_o),
    .giveup_o    (giveup_o),
    .tx_err_o    (tx_err_o),
    .retry_cnt_o (retry_cnt_o)
);

// File: tb/tx_deadlock_guard_tb.sv
module tx_deadlock_guard_tb;
    localparam int RC = 2;      // reset pulse cycles
    localparam int SC = 10;     // 200 ns at 50 MHz
    localparam int TC = 100;    // 2000 ns at 50 MHz
    localparam int MR = 5;
    localparam int CW = 2;

    localparam int K_RST = 0, K_GAP = 1, K_REQ = 2, K_DONE = 3, K_GIVE = 4;

    typedef struct { int kind; int val; string tag; } ev_t;
    ev_t exp_q[$];

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic send_i = 1'b0, mac_done_i = 1'b0, req_clr_i = 1'b0, mac_err_i = 1'b0;
    logic txrst_o, req_o, done_o, giveup_o, tx_err_o;
    logic [CW-1:0] retry_cnt_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #10 clk = ~clk;

    tx_deadlock_guard #(
        .CLK_HZ(50_000_000), .SETTLE_NS(200), .TIMEOUT_NS(2000),
        .RST_CYC(RC), .MAX_RETRY(MR), .CNT_W(CW)
    ) u_dut (
        .clk(clk), .rst(rst), .send_i(send_i), .mac_done_i(mac_done_i),
        .req_clr_i(req_clr_i), .mac_err_i(mac_err_i), .txrst_o(txrst_o),
        .req_o(req_o), .done_o(done_o), .giveup_o(giveup_o),
        .tx_err_o(tx_err_o), .retry_cnt_o(retry_cnt_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic push(input int kind, input int val, input string tag);
        ev_t e;
        e.kind = kind; e.val = val; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic push_attempt(input int req_len, input string tag);
        push(K_RST, RC, "R2");
        push(K_GAP, SC, "R3");
        push(K_REQ, req_len, tag);
    endtask

    function automatic void sb_compare(input int kind, input int val);
        ev_t e;
        checks++;
        if (exp_q.size() == 0) begin
            errors++;
            $display("FAIL R11: unexpected event kind %0d actual %0d expected none", kind, val);
            return;
        end
        e = exp_q.pop_front();
        if (e.kind != kind || e.val != val) begin
            errors++;
            $display("FAIL %s: event kind %0d value %0d, actual kind %0d value %0d",
                     e.tag, e.kind, e.val, kind, val);
        end
    endfunction

    // Monitor: measures phase lengths at the falling edge.
    logic p_txrst = 1'b0, p_req = 1'b0;
    int rst_run = 0, req_run = 0, gap = 0;
    always @(negedge clk) begin
        if (!rst) begin
            if (p_req && !req_o) sb_compare(K_REQ, req_run);
            if (done_o)          sb_compare(K_DONE, int'(retry_cnt_o));
            if (giveup_o)        sb_compare(K_GIVE, int'(retry_cnt_o));
            if (p_txrst && !txrst_o) sb_compare(K_RST, rst_run);
            if (!p_req && req_o) sb_compare(K_GAP, gap);
            check(!(txrst_o && req_o), "R4", int'(txrst_o && req_o), 0);
            if (p_txrst && !txrst_o)   gap = 1;
            else if (!txrst_o && !req_o) gap++;
            rst_run = txrst_o ? rst_run + 1 : 0;
            req_run = req_o ? req_run + 1 : 0;
            p_txrst = txrst_o;
            p_req   = req_o;
        end
    end

    task automatic send_pulse();
        send_i = 1'b1;
        @(negedge clk);
        send_i = 1'b0;
    endtask

    task automatic wait_rise();
        @(negedge clk);
        while (req_o) @(negedge clk);
        while (!req_o) @(negedge clk);
    endtask

    // Completion raised so the request lasts exactly j cycles (called at the rise).
    task automatic complete_after(input int j, input bit use_done);
        repeat (j - 1) @(negedge clk);
        if (use_done) mac_done_i = 1'b1; else req_clr_i = 1'b1;
        @(negedge clk);
        mac_done_i = 1'b0;
        req_clr_i  = 1'b0;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected fewer than 20000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(txrst_o == 0, "R1 txrst", int'(txrst_o), 0);
        check(req_o == 0, "R1 req", int'(req_o), 0);
        check(done_o == 0 && giveup_o == 0, "R1 pulses", int'(done_o | giveup_o), 0);
        check(tx_err_o == 0, "R1 err", int'(tx_err_o), 0);
        check(retry_cnt_o == 0, "R1 count", int'(retry_cnt_o), 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        check(txrst_o == 0 && req_o == 0, "R1 idle", int'({txrst_o, req_o}), 0);

        // Frame A: completion via req_clr_i after 30 cycles; error filtering (R10, R5)
        push_attempt(30, "R5");
        push(K_DONE, 0, "R5");
        send_pulse();
        repeat (2) @(negedge clk);          // now in first settle cycle
        mac_err_i = 1'b1;
        @(negedge clk);
        mac_err_i = 1'b0;
        check(tx_err_o == 0, "R10 settle err ignored", int'(tx_err_o), 0);
        wait_rise();
        mac_err_i = 1'b1;
        @(negedge clk);
        mac_err_i = 1'b0;
        check(tx_err_o == 1, "R10 request err passed", int'(tx_err_o), 1);
        repeat (30 - 2) @(negedge clk);
        req_clr_i = 1'b1;
        @(negedge clk);
        req_clr_i = 1'b0;
        repeat (3) @(negedge clk);

        // Frame B: completion via mac_done_i in the last window cycle (R7)
        push_attempt(TC, "R7");
        push(K_DONE, 0, "R7");
        send_pulse();
        wait_rise();
        complete_after(TC, 1'b1);
        repeat (3) @(negedge clk);

        // Frame C: one timeout then completion; send while busy ignored (R6, R11)
        push_attempt(TC, "R6");
        push_attempt(5, "R6");
        push(K_DONE, 1, "R6");
        send_pulse();
        wait_rise();
        send_pulse();                       // R11: must not disturb the sequence
        wait_rise();
        complete_after(5, 1'b0);
        repeat (3) @(negedge clk);

        // Frame D: never completes; give-up after MR retries, count saturated (R8, R9)
        for (int i = 0; i <= MR; i++) push_attempt(TC, "R8");
        push(K_GIVE, 3, "R9");
        send_pulse();
        repeat ((MR + 1) * (RC + SC + TC) + 5) @(negedge clk);
        check(txrst_o == 0 && req_o == 0, "R8 idle after give-up", int'({txrst_o, req_o}), 0);

        // Frame E: count cleared by a new send (R9)
        push_attempt(1, "R9");
        push(K_DONE, 0, "R9");
        send_pulse();
        check(retry_cnt_o == 0, "R9 cleared", int'(retry_cnt_o), 0);
        wait_rise();
        complete_after(1, 1'b0);
        repeat (5) @(negedge clk);

        check(exp_q.size() == 0, "R2 scoreboard drained", exp_q.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule